// File: doc/BRIEF.md
# Binned Functional Coverage Collector

This block watches a stream of sampled parameter values and records how well each value range has been exercised. On every cycle with `sample_valid` high it takes one value per monitored variable from a packed bus. Each variable's value space is cut into a power-of-two number of equal-width bins, and the bin that holds the value gains one hit. Every variable is binned on its own from the same strobe, and no combinations of variables are tracked.

Each bin has a hit counter that stops at a programmable minimum-hit threshold. A variable is done when every bin in its programmed resolution has reached that threshold. A three-state controller declares full coverage once all enabled variables are done. The states are IDLE (after reset or clear, waiting for the first sample), COLLECT (sampling, coverage not yet reached) and FULL (coverage reached). The transitions are:

- IDLE to COLLECT on the first valid sample.
- COLLECT to FULL when every enabled variable is done.
- FULL back to COLLECT when that condition is lost, for example after the threshold is raised.
- Any state to IDLE on `clear`.

A combinational read port returns the count of any bin.

Top module: `cov_collector`

## Requirements
- R1: Variable i takes its value from `sample_vals[8i+7:8i]` and its resolution code from `bins_log2[3i+2:3i]`. The number of bins is 2 to the power of the code, and a value's bin is its top code bits. A code of 0 gives a single bin, 0.
- R2: A valid sample adds exactly one hit to one bin of every enabled variable, and all variables are updated on the same strobe.
- R3: A resolution code above 4 is treated as 4, which gives 16 bins.
- R4: The counters of a variable whose `var_enable` bit is 0 do not change. Its `var_done` bit stays 0, and the variable is left out of the full-coverage decision.
- R5: A bin counter stops increasing once it equals `min_hits`.
- R6: `var_done[i]` is high when every bin below 2^code of enabled variable i holds at least `min_hits`. It reflects the counters in the same cycle they change.
- R7: `full_cov` rises one clock after every enabled variable is done, with at least one variable enabled (COLLECT to FULL). It falls one clock after that condition is lost (FULL to COLLECT).
- R8: `clear` synchronously zeroes all counters and returns the controller to IDLE, so `full_cov` is low after the clearing edge.
- R9: `rd_count` shows the count of bin `rd_bin` of variable `rd_var` without a clock delay. An `rd_var` of 3 or more reads as 0.
- R10: After reset every counter, every `var_done` bit and `full_cov` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of counters and controller |
| sample_valid | input | 1 | Sample strobe |
| sample_vals | input | 24 | Packed sample values, 8 bits per variable |
| var_enable | input | 3 | Per-variable enable |
| bins_log2 | input | 9 | Packed resolution codes, 3 bits per variable |
| min_hits | input | 8 | Minimum hits per bin |
| rd_var | input | 2 | Read-port variable index |
| rd_bin | input | 4 | Read-port bin index |
| rd_count | output | 8 | Selected bin count |
| var_done | output | 3 | Per-variable done flags |
| full_cov | output | 1 | Full coverage reached |

## Verification
A sample presented before a rising edge shows up in `rd_count` and `var_done` right after that edge. `full_cov` follows one edge later because it comes from the controller's state register. The bench drives every input on the falling edge and checks counts and done flags at the next falling edge. It checks `full_cov` once at that point, where it must still be low, and again one falling edge later, where it must be high. A threshold change moves `var_done` with no edge at all, so it is checked 1 ns after the drive, while `full_cov` is checked over the following edge.

// File: rtl/cov_pkg.sv
package cov_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_FULL    = 2'd2
    } cov_state_e;
endpackage

// File: rtl/cov_bin_index.sv
module cov_bin_index #(
    parameter int VAL_W        = 8,
    parameter int MAX_BINS_LOG = 4,
    parameter int LOG_W        = 3
) (
    input  logic [VAL_W-1:0]        value,
    input  logic [LOG_W-1:0]        bins_log2,
    output logic [MAX_BINS_LOG-1:0] bin_idx,
    output logic [LOG_W-1:0]        eff_log2
);
    logic [VAL_W-1:0] shifted;

    always_comb begin
        // clamp the resolution code to the widest supported bank
        if (bins_log2 > LOG_W'(MAX_BINS_LOG))
            eff_log2 = LOG_W'(MAX_BINS_LOG);
        else
            eff_log2 = bins_log2;
        // equal-width bins: the index is the top eff_log2 bits of the value
        shifted = value >> (32'(VAL_W) - 32'(eff_log2));
        bin_idx = shifted[MAX_BINS_LOG-1:0];
    end
endmodule

// File: rtl/cov_var_bank.sv
module cov_var_bank #(
    parameter int MAX_BINS_LOG = 4,
    parameter int CNT_W        = 8,
    parameter int LOG_W        = 3,
    localparam int NBINS       = 1 << MAX_BINS_LOG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    enable,
    input  logic                    hit,
    input  logic [MAX_BINS_LOG-1:0] hit_bin,
    input  logic [LOG_W-1:0]        eff_log2,
    input  logic [CNT_W-1:0]        min_hits,
    output logic [NBINS*CNT_W-1:0]  counts,
    output logic                    done
);
    logic [NBINS-1:0] bin_met;

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        logic [CNT_W-1:0] cnt_q;
        logic             in_use;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (clear)
                cnt_q <= '0;
            else if (enable && hit && hit_bin == MAX_BINS_LOG'(b) && cnt_q < min_hits)
                cnt_q <= cnt_q + 1'b1;
        end

        assign in_use                   = 32'(b) < (32'd1 << eff_log2);
        assign bin_met[b]               = !in_use || (cnt_q >= min_hits);
        assign counts[b*CNT_W +: CNT_W] = cnt_q;
    end

    assign done = enable && (&bin_met);
endmodule

// File: rtl/cov_ctrl_fsm.sv
module cov_ctrl_fsm
    import cov_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample_valid,
    input  logic all_done,
    output logic full_cov
);
    cov_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (sample_valid) state_d = ST_COLLECT;
            ST_COLLECT: if (all_done)     state_d = ST_FULL;
            ST_FULL:    if (!all_done)    state_d = ST_COLLECT;
            default:                      state_d = ST_IDLE;
        endcase
        if (clear)
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        full_cov = (state_q == ST_FULL);
    end
endmodule

// File: rtl/cov_collector.sv
module cov_collector #(
    parameter int NUM_VARS     = 3,
    parameter int VAL_W        = 8,
    parameter int MAX_BINS_LOG = 4,
    parameter int CNT_W        = 8,
    localparam int LOG_W       = $clog2(MAX_BINS_LOG + 1),
    localparam int VAR_IDX_W   = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1,
    localparam int NBINS       = 1 << MAX_BINS_LOG
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      sample_valid,
    input  logic [NUM_VARS*VAL_W-1:0] sample_vals,
    input  logic [NUM_VARS-1:0]       var_enable,
    input  logic [NUM_VARS*LOG_W-1:0] bins_log2,
    input  logic [CNT_W-1:0]          min_hits,
    input  logic [VAR_IDX_W-1:0]      rd_var,
    input  logic [MAX_BINS_LOG-1:0]   rd_bin,
    output logic [CNT_W-1:0]          rd_count,
    output logic [NUM_VARS-1:0]       var_done,
    output logic                      full_cov
);
    logic [NBINS*CNT_W-1:0] bank_counts [NUM_VARS];
    logic                   all_done;

    for (genvar v = 0; v < NUM_VARS; v++) begin : g_var
        logic [MAX_BINS_LOG-1:0] bin_idx;
        logic [LOG_W-1:0]        eff_log2;

        cov_bin_index #(
            .VAL_W(VAL_W), .MAX_BINS_LOG(MAX_BINS_LOG), .LOG_W(LOG_W)
        ) u_idx (
            .value    (sample_vals[v*VAL_W +: VAL_W]),
            .bins_log2(bins_log2[v*LOG_W +: LOG_W]),
            .bin_idx  (bin_idx),
            .eff_log2 (eff_log2)
        );

        cov_var_bank #(
            .MAX_BINS_LOG(MAX_BINS_LOG), .CNT_W(CNT_W), .LOG_W(LOG_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .enable  (var_enable[v]),
            .hit     (sample_valid),
            .hit_bin (bin_idx),
            .eff_log2(eff_log2),
            .min_hits(min_hits),
            .counts  (bank_counts[v]),
            .done    (var_done[v])
        );
    end

    assign all_done = (|var_enable) && (&(var_done | ~var_enable));

    cov_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .sample_valid(sample_valid),
        .all_done    (all_done),
        .full_cov    (full_cov)
    );

    always_comb begin
        rd_count = '0;
        for (int v = 0; v < NUM_VARS; v++) begin
            if (rd_var == VAR_IDX_W'(v))
                rd_count = bank_counts[v][32'(rd_bin)*CNT_W +: CNT_W];
        end
    end
endmodule

// File: rtl/cov_collector_chk.sv
module cov_collector_chk #(
    parameter int NUM_VARS     = 3,
    parameter int MAX_BINS_LOG = 4,
    parameter int CNT_W        = 8,
    parameter int VAR_IDX_W    = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clear,
    input logic [NUM_VARS-1:0]     var_enable,
    input logic [CNT_W-1:0]        min_hits,
    input logic [VAR_IDX_W-1:0]    rd_var,
    input logic [MAX_BINS_LOG-1:0] rd_bin,
    input logic [CNT_W-1:0]        rd_count,
    input logic [NUM_VARS-1:0]     var_done,
    input logic                    full_cov
);
    logic sel_ok;
    logic every_done;
    assign sel_ok     = (32'(rd_var) < NUM_VARS);
    assign every_done = (|var_enable) && (&(var_done | ~var_enable));

    // R7: full coverage only rises after all enabled variables were done
    a_r7_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_cov) |-> $past(every_done));

    // R8: clear drops full coverage on the following edge
    a_r8_clear_drops_full: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> !full_cov);

    // R8: after clear, counters are zero so no variable is done with a nonzero threshold
    a_r8_clear_undone: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear) && min_hits != '0) |-> var_done == '0);

    // R2: a watched bin grows by at most one per clock
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_var) && $stable(rd_bin) && !$past(clear)) |->
        (rd_count == $past(rd_count) || rd_count == $past(rd_count) + 1'b1));

    // R5: a bin at the threshold does not grow while the threshold holds
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_var) && $stable(rd_bin) && $stable(min_hits) && !$past(clear)
         && $past(rd_count) == min_hits) |-> rd_count == $past(rd_count));

    // R4: a disabled variable's bins stay put
    a_r4_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_var) && $stable(rd_bin) && !$past(clear) && $past(sel_ok)
         && !$past(var_enable[rd_var])) |-> rd_count == $past(rd_count));
endmodule

bind cov_collector cov_collector_chk #(
    .NUM_VARS(NUM_VARS), .MAX_BINS_LOG(MAX_BINS_LOG),
    .CNT_W(CNT_W), .VAR_IDX_W(VAR_IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .var_enable(var_enable),
    .min_hits(min_hits), .rd_var(rd_var), .rd_bin(rd_bin),
    .rd_count(rd_count), .var_done(var_done), .full_cov(full_cov)
);

// File: tb/tb_cov_collector.sv
module tb_cov_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        sample_valid = 1'b0;
    logic [23:0] sample_vals = '0;
    logic [2:0]  var_enable = 3'b111;
    logic [8:0]  bins_log2 = '0;
    logic [7:0]  min_hits = 8'd3;
    logic [1:0]  rd_var = '0;
    logic [3:0]  rd_bin = '0;
    logic [7:0]  rd_count;
    logic [2:0]  var_done;
    logic        full_cov;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cov_collector dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .sample_valid(sample_valid),
        .sample_vals(sample_vals), .var_enable(var_enable), .bins_log2(bins_log2),
        .min_hits(min_hits), .rd_var(rd_var), .rd_bin(rd_bin),
        .rd_count(rd_count), .var_done(var_done), .full_cov(full_cov)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_bin(input string req, input int v, input int b, input int exp);
        rd_var = 2'(v);
        rd_bin = 4'(b);
        #1;
        chk(req, int'(rd_count), exp);
    endtask

    // entered and left on a falling edge
    task automatic do_sample(input logic [23:0] v);
        sample_vals  = v;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 full_cov", int'(full_cov), 0);
        chk("R10 var_done", int'(var_done), 0);
        chk_bin("R10 count", 0, 0, 0);
        chk_bin("R10 count", 2, 15, 0);
    endtask

    task automatic t_binning();
        do_clear();
        var_enable = 3'b111;
        min_hits   = 8'd3;
        bins_log2  = {3'd1, 3'd3, 3'd2};
        do_sample({8'h45, 8'h45, 8'h45});
        chk_bin("R1 v0 bin1", 0, 1, 1);
        chk_bin("R1 v0 bin0", 0, 0, 0);
        chk_bin("R1 v1 bin2", 1, 2, 1);
        chk_bin("R2 v2 bin0", 2, 0, 1);
        do_sample({8'hC0, 8'hFF, 8'hFF});
        chk_bin("R1 v0 bin3", 0, 3, 1);
        chk_bin("R1 v1 bin7", 1, 7, 1);
        chk_bin("R2 v2 bin1", 2, 1, 1);
        chk_bin("R2 v1 bin2 unchanged", 1, 2, 1);
        bins_log2 = {3'd1, 3'd3, 3'd0};
        do_sample({8'h00, 8'h00, 8'hFF});
        chk_bin("R1 v0 one bin", 0, 0, 1);
    endtask

    task automatic t_clamp();
        do_clear();
        bins_log2 = {3'd1, 3'd7, 3'd2};
        do_sample({8'h00, 8'hF3, 8'h00});
        chk_bin("R3 v1 bin15", 1, 15, 1);
        do_sample({8'h00, 8'h0F, 8'h00});
        chk_bin("R3 v1 bin0", 1, 0, 1);
    endtask

    task automatic t_disabled();
        do_clear();
        bins_log2  = {3'd1, 3'd2, 3'd2};
        min_hits   = 8'd1;
        var_enable = 3'b011;
        do_sample({8'h00, 8'h00, 8'h00});
        chk_bin("R4 v2 frozen", 2, 0, 0);
        chk_bin("R4 v0 counted", 0, 0, 1);
        chk("R4 v2 not done", int'(var_done[2]), 0);
        var_enable = 3'b111;
    endtask

    task automatic t_saturate();
        do_clear();
        bins_log2 = {3'd1, 3'd2, 3'd2};
        min_hits  = 8'd3;
        for (int i = 0; i < 5; i++) do_sample({8'h00, 8'h00, 8'h10});
        chk_bin("R5 saturated", 0, 0, 3);
        chk("R6 v0 partial not done", int'(var_done[0]), 0);
    endtask

    task automatic t_full();
        do_clear();
        var_enable = 3'b011;
        bins_log2  = {3'd1, 3'd2, 3'd3};
        min_hits   = 8'd100;
        for (int k = 0; k < 799; k++)
            do_sample({8'h00, 8'((k % 4) * 64), 8'((k % 8) * 32)});
        chk("R6 v0 one short", int'(var_done[0]), 0);
        chk("R6 v1 done", int'(var_done[1]), 1);
        chk("R7 full low before", int'(full_cov), 0);
        chk_bin("R5 v1 capped at 100", 1, 0, 100);
        do_sample({8'h00, 8'h00, 8'hE0});
        chk("R6 v0 done", int'(var_done), 3);
        chk("R7 full not yet", int'(full_cov), 0);
        @(negedge clk);
        chk("R7 full rises", int'(full_cov), 1);
        min_hits = 8'd200;
        #1;
        chk("R6 done drops", int'(var_done), 0);
        chk("R7 full held", int'(full_cov), 1);
        @(negedge clk);
        chk("R7 full falls", int'(full_cov), 0);
    endtask

    task automatic t_clear_read();
        min_hits = 8'd100;
        chk_bin("R9 read v0 bin7", 0, 7, 100);
        chk_bin("R9 out of range var", 3, 0, 0);
        do_clear();
        chk_bin("R8 cleared", 0, 7, 0);
        chk("R8 full low", int'(full_cov), 0);
        chk("R8 done low", int'(var_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_binning();
        t_clamp();
        t_disabled();
        t_saturate();
        t_full();
        t_clear_read();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule